// File: doc/BRIEF.md
# Match-Compare Event Timer

This block is an 8-bit event counter with a programmable compare value. It advances on single-cycle enable pulses taken from one of three sources: an external pin whose active edge is selectable, an instruction-cycle strobe, or a 1 kHz reference tick. All of these are seen in the system clock domain. When a count step lands on the compare value, the block emits a one-cycle match pulse and latches an interrupt flag. The flag reaches the interrupt output only while the interrupt-enable input is high.

Software uses a 4-bit register port with a 3-bit address. The compare value and the running count each take two nibble addresses, low nibble first. A control nibble holds the source select, the gate and a self-clearing counter clear. A mode nibble holds the auto-clear disable and the pin polarity. A status nibble holds the interrupt flag, which is cleared by writing 1. After a match the counter can either restart from zero or keep running and wrap.

Top module: `match_timer`

## Requirements
- R1: The count is an 8-bit binary value that rises by exactly 1 per accepted enable pulse. It reads back at address 2 (bits 3:0) and address 3 (bits 7:4), and it is 0 after reset.
- R2: The compare value is written and read as two nibbles: address 0 holds bits 3:0 and address 1 holds bits 7:4. A write to one address leaves the other nibble unchanged.
- R3: When an accepted count step makes the count equal the compare value, `match_pulse` is high for exactly the following cycle and the interrupt flag is set on the same clock edge.
- R4: With mode bit 0 at 0, a count step taken while the count equals the compare value loads 0 instead of count+1.
- R5: With mode bit 0 at 1, the counter steps past the compare value and wraps from 255 to 0.
- R6: Writing 1 to control bit 3 (address 4) clears the count on the next edge. This clear wins over a count step in the same cycle, and the bit always reads back 0.
- R7: Control bits 1:0 select the source: 00 is the pin, 01 is `instr_tick`, and 10 or 11 is `ref_tick`. Pulses on a source that is not selected leave the count unchanged.
- R8: With the pin selected, mode bit 1 at 0 counts rising edges and at 1 counts falling edges. The count changes on the third system clock edge that samples the new pin level.
- R9: Control bit 2 is a gate. While it is 0 the count holds its value, and it is 0 after reset.
- R10: The interrupt flag reads at address 6 bit 0. It stays set until software writes 1 to that bit, and a set in the same cycle as that write wins.
- R11: `irq` is high exactly when the interrupt flag is set and `int_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 4 | Write data nibble |
| reg_rdata | output | 4 | Read data nibble for the addressed register (combinational) |
| ext_pin | input | 1 | Asynchronous external count pin |
| instr_tick | input | 1 | Instruction-cycle strobe, one cycle wide |
| ref_tick | input | 1 | 1 kHz reference strobe, one cycle wide |
| int_en | input | 1 | Interrupt enable |
| match_pulse | output | 1 | One-cycle compare-hit pulse |
| irq | output | 1 | Interrupt request |

## Verification
Two kinds of conflict can occur in a single cycle. The first is a count step together with the software clear: the bench holds `instr_tick` high in the same cycle as the clear write, and passes only if the count reads 0 afterwards. The second is a compare hit together with a write-1 to the status flag: the bench steps the counter onto the compare value in the same cycle as the flag write, and passes only if the flag reads back as set.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
    localparam int CNT_W  = 8;
    localparam int NIB_W  = 4;
    localparam int ADDR_W = 3;
    localparam int NIBS   = CNT_W / NIB_W;

    localparam logic [ADDR_W-1:0] ADR_CMP_LO  = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_CNT_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CTRL    = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_MODE    = 3'd5;
    localparam logic [ADDR_W-1:0] ADR_STAT    = 3'd6;

    typedef enum logic [1:0] {
        SRC_PIN   = 2'b00,
        SRC_INSTR = 2'b01,
        SRC_REF0  = 2'b10,
        SRC_REF1  = 2'b11
    } src_sel_e;
endpackage

// File: rtl/mt_src_sel.sv
module mt_src_sel
    import match_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     ext_pin,
    input  logic     instr_tick,
    input  logic     ref_tick,
    input  src_sel_e sel,
    input  logic     pol,
    input  logic     gate,
    output logic     cnt_en
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } src_state_t;

    src_state_t st_d, st_q;
    logic level, pin_edge, src_pulse;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[TOP-1:0], ext_pin};
        st_d.last = st_q.sync[TOP];
        level     = st_q.sync[TOP];
        pin_edge  = pol ? (st_q.last & ~level) : (level & ~st_q.last);
        unique case (sel)
            SRC_PIN:   src_pulse = pin_edge;
            SRC_INSTR: src_pulse = instr_tick;
            default:   src_pulse = ref_tick;
        endcase
        cnt_en = gate & src_pulse;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: a pin-sourced count enable needs a level change seen at the synchronizer output
    assert_pin_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && sel == SRC_PIN) |-> (st_q.last != st_q.sync[TOP]));
endmodule

// File: rtl/mt_regs.sv
module mt_regs
    import match_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NIB_W-1:0]  reg_wdata,
    output logic [NIB_W-1:0]  reg_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              flag,
    output logic [CNT_W-1:0]  cmp_val,
    output src_sel_e          sel,
    output logic              gate,
    output logic              auto_off,
    output logic              pol,
    output logic              sw_clr,
    output logic              flag_clr
);
    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        src_sel_e         sel;
        logic             gate;
        logic             auto_off;
        logic             pol;
    } reg_state_t;

    reg_state_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        for (int i = 0; i < NIBS; i++) begin
            if (reg_wr && reg_addr == ADR_CMP_LO + ADDR_W'(i))
                rg_d.cmp[i*NIB_W +: NIB_W] = reg_wdata;
        end
        if (reg_wr && reg_addr == ADR_CTRL) begin
            rg_d.sel  = src_sel_e'(reg_wdata[1:0]);
            rg_d.gate = reg_wdata[2];
        end
        if (reg_wr && reg_addr == ADR_MODE) begin
            rg_d.auto_off = reg_wdata[0];
            rg_d.pol      = reg_wdata[1];
        end
        sw_clr   = reg_wr && (reg_addr == ADR_CTRL) && reg_wdata[3];
        flag_clr = reg_wr && (reg_addr == ADR_STAT) && reg_wdata[0];

        reg_rdata = '0;
        for (int i = 0; i < NIBS; i++) begin
            if (reg_addr == ADR_CMP_LO + ADDR_W'(i)) reg_rdata = rg_q.cmp[i*NIB_W +: NIB_W];
            if (reg_addr == ADR_CNT_LO + ADDR_W'(i)) reg_rdata = count[i*NIB_W +: NIB_W];
        end
        if (reg_addr == ADR_CTRL) reg_rdata = {1'b0, rg_q.gate, rg_q.sel};
        if (reg_addr == ADR_MODE) reg_rdata = {2'b00, rg_q.pol, rg_q.auto_off};
        if (reg_addr == ADR_STAT) reg_rdata = {3'b000, flag};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign cmp_val  = rg_q.cmp;
    assign sel      = rg_q.sel;
    assign gate     = rg_q.gate;
    assign auto_off = rg_q.auto_off;
    assign pol      = rg_q.pol;

    // R2: a low-nibble compare write lands and leaves the high nibble alone
    assert_cmp_lo_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(reg_wr && reg_addr == ADR_CMP_LO) |->
            (cmp_val[NIB_W-1:0] == $past(reg_wdata)) &&
            (cmp_val[CNT_W-1:NIB_W] == $past(cmp_val[CNT_W-1:NIB_W])));
endmodule

// File: rtl/mt_core.sv
module mt_core
    import match_timer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             auto_off,
    input  logic             sw_clr,
    input  logic             flag_clr,
    input  logic [CNT_W-1:0] cmp_val,
    output logic [CNT_W-1:0] count,
    output logic             match_pulse,
    output logic             flag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pulse;
        logic             flag;
    } core_state_t;

    core_state_t cs_d, cs_q;
    logic [CNT_W-1:0] step;

    always_comb begin
        cs_d = cs_q;
        if (!auto_off && cs_q.cnt == cmp_val) step = '0;
        else                                  step = cs_q.cnt + 1'b1;
        if (sw_clr)      cs_d.cnt = '0;
        else if (cnt_en) cs_d.cnt = step;
        cs_d.pulse = !sw_clr && cnt_en && (step == cmp_val);
        cs_d.flag  = cs_d.pulse || (cs_q.flag && !flag_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cs_q <= '0;
        else        cs_q <= cs_d;
    end

    assign count       = cs_q.cnt;
    assign match_pulse = cs_q.pulse;
    assign flag        = cs_q.flag;

    // R3: a match pulse only follows an accepted count step, and the flag is set alongside it
    assert_pulse_from_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |-> ($past(cnt_en) && flag));
    // R4: auto-clear sends a step taken at the compare value to zero
    assert_auto_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_en && !auto_off && !sw_clr && count == cmp_val) |-> (count == '0));
    // R5: with auto-clear off every step is +1 modulo 256
    assert_free_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cnt_en && auto_off && !sw_clr) |-> (count == $past(count) + 1'b1));
    // R6: software clear forces zero
    assert_sw_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_clr) |-> (count == '0));
    // R9: without an enable the count holds
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cnt_en && !sw_clr) |-> $stable(count));
    // R10: the flag only drops on a write-1 clear
    assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(flag_clr));
endmodule

// File: rtl/match_timer.sv
module match_timer
    import match_timer_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NIB_W-1:0]  reg_wdata,
    output logic [NIB_W-1:0]  reg_rdata,
    input  logic              ext_pin,
    input  logic              instr_tick,
    input  logic              ref_tick,
    input  logic              int_en,
    output logic              match_pulse,
    output logic              irq
);
    logic [CNT_W-1:0] count, cmp_val;
    src_sel_e         sel;
    logic             gate, auto_off, pol, sw_clr, flag_clr, cnt_en, flag;

    mt_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count(count), .flag(flag),
        .cmp_val(cmp_val), .sel(sel), .gate(gate), .auto_off(auto_off), .pol(pol),
        .sw_clr(sw_clr), .flag_clr(flag_clr)
    );

    mt_src_sel #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .instr_tick(instr_tick),
        .ref_tick(ref_tick), .sel(sel), .pol(pol), .gate(gate), .cnt_en(cnt_en)
    );

    mt_core u_core (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .auto_off(auto_off),
        .sw_clr(sw_clr), .flag_clr(flag_clr), .cmp_val(cmp_val), .count(count),
        .match_pulse(match_pulse), .flag(flag)
    );

    assign irq = flag & int_en;

    // R11: the request stays low while the interrupt enable is low
    assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq);
endmodule

// File: tb/match_timer_test.sv
module match_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_wdata = '0;
    logic [3:0] reg_rdata;
    logic       ext_pin = 1'b0, instr_tick = 1'b0, ref_tick = 1'b0, int_en = 1'b1;
    logic       match_pulse, irq;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;   // 0 read data, 1 match_pulse, 2 irq
        logic [3:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    match_timer uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_pin(ext_pin),
        .instr_tick(instr_tick), .ref_tick(ref_tick), .int_en(int_en),
        .match_pulse(match_pulse), .irq(irq)
    );

    always #2 clk = ~clk;

    // monitor: compares queued expectations just after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                logic [3:0] act;
                it = sb.pop_front();
                case (it.kind)
                    0:       act = reg_rdata;
                    1:       act = {3'b000, match_pulse};
                    default: act = {3'b000, irq};
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
                end
            end
        end
    end

    task automatic expect_item(input int kind, input logic [2:0] a, input logic [3:0] e, input string tag);
        item_t it;
        if (kind == 0) reg_addr = a;
        it.kind = kind; it.exp = e; it.tag = tag;
        sb.push_back(it);
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [3:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic instr_run(input int n);
        instr_tick = 1'b1;
        repeat (n) @(negedge clk);
        instr_tick = 1'b0;
    endtask

    task automatic ref_run(input int n);
        ref_tick = 1'b1;
        repeat (n) @(negedge clk);
        ref_tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_item(0, 3'd2, 4'h0, "R1 reset count");
        expect_item(2, 3'd0, 4'h0, "R11 reset irq");
        expect_item(0, 3'd4, 4'h0, "R9 reset gate off");

        wr(3'd0, 4'h5); wr(3'd1, 4'h3);
        expect_item(0, 3'd0, 4'h5, "R2 cmp low");
        expect_item(0, 3'd1, 4'h3, "R2 cmp high");

        wr(3'd4, 4'b0001);
        instr_run(3);
        expect_item(0, 3'd2, 4'h0, "R9 gated hold");

        wr(3'd4, 4'b0101);
        instr_run(3);
        expect_item(0, 3'd2, 4'h3, "R1 three steps");
        ref_run(2);
        ext_pin = 1'b1; repeat (4) @(negedge clk);
        ext_pin = 1'b0; repeat (4) @(negedge clk);
        expect_item(0, 3'd2, 4'h3, "R7 unselected sources");

        wr(3'd4, 4'b0110);
        ref_run(2);
        expect_item(0, 3'd2, 4'h5, "R7 ref select 10");
        wr(3'd4, 4'b0111);
        ref_run(1);
        expect_item(0, 3'd2, 4'h6, "R7 ref select 11");

        wr(3'd0, 4'h7); wr(3'd1, 4'h0);
        wr(3'd4, 4'b0101);
        instr_run(1);
        expect_item(1, 3'd0, 4'h1, "R3 pulse on hit");
        expect_item(1, 3'd0, 4'h0, "R3 pulse one cycle");
        expect_item(0, 3'd6, 4'h1, "R10 flag set");
        expect_item(2, 3'd0, 4'h1, "R11 irq enabled");
        expect_item(0, 3'd2, 4'h7, "R1 count low");
        expect_item(0, 3'd3, 4'h0, "R1 count high");

        instr_run(1);
        expect_item(0, 3'd2, 4'h0, "R4 auto clear");

        wr(3'd6, 4'h1);
        expect_item(0, 3'd6, 4'h0, "R10 write-1 clear");
        expect_item(2, 3'd0, 4'h0, "R11 irq after clear");

        int_en = 1'b0;
        instr_run(7);
        expect_item(2, 3'd0, 4'h0, "R11 irq masked");
        expect_item(0, 3'd6, 4'h1, "R10 flag while masked");
        int_en = 1'b1;
        expect_item(2, 3'd0, 4'h1, "R11 irq unmasked");
        wr(3'd6, 4'h1);

        wr(3'd5, 4'b0001);
        instr_run(1);
        expect_item(0, 3'd2, 4'h8, "R5 steps past compare");
        instr_run(247);
        expect_item(0, 3'd2, 4'hF, "R5 count 255 low");
        expect_item(0, 3'd3, 4'hF, "R5 count 255 high");
        instr_run(1);
        expect_item(0, 3'd2, 4'h0, "R5 wrap low");
        expect_item(0, 3'd3, 4'h0, "R5 wrap high");

        instr_run(5);
        instr_tick = 1'b1;
        wr(3'd4, 4'b1101);
        instr_tick = 1'b0;
        expect_item(0, 3'd2, 4'h0, "R6 clear beats step");
        expect_item(0, 3'd4, 4'b0101, "R6 clear bit reads 0");

        wr(3'd6, 4'h1);
        expect_item(0, 3'd6, 4'h0, "R10 flag cleared");
        instr_run(6);
        instr_tick = 1'b1;
        wr(3'd6, 4'h1);
        instr_tick = 1'b0;
        expect_item(0, 3'd6, 4'h1, "R10 set wins over clear");

        wr(3'd4, 4'b1100);
        ext_pin = 1'b1;
        @(negedge clk); @(negedge clk);
        expect_item(0, 3'd2, 4'h0, "R8 not yet counted");
        expect_item(0, 3'd2, 4'h1, "R8 rising counted");
        ext_pin = 1'b0; repeat (4) @(negedge clk);
        expect_item(0, 3'd2, 4'h1, "R8 falling ignored");
        wr(3'd5, 4'b0011);
        ext_pin = 1'b1; repeat (4) @(negedge clk);
        expect_item(0, 3'd2, 4'h1, "R8 rising ignored");
        ext_pin = 1'b0; repeat (4) @(negedge clk);
        expect_item(0, 3'd2, 4'h2, "R8 falling counted");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule